// File: doc/BRIEF.md
# UART FIFO Watermark Register Interface

This block is the register-facing front end of a UART. It holds one transmit queue and one receive queue, each eight bytes deep. It also decodes a small 32-bit register bus into four word registers: transmit data, receive data, transmit control and receive control. The serial shifters sit outside the block. The transmitter side takes bytes from the head of the transmit queue, and the receiver side pushes the bytes it assembles into the receive queue.

Each queue drives a level-sensitive watermark interrupt. The receive interrupt is high while the receive queue holds more bytes than its programmed threshold. The transmit interrupt is high while the transmit queue holds fewer bytes than its threshold. Each interrupt is gated by an enable bit that arrives as an input pin.

Each queue's occupancy is tracked by a three-state machine with the states OCC_EMPTY, OCC_PART and OCC_FULL. It has four named transitions:

- FILL: OCC_EMPTY to OCC_PART, taken on an accepted push.
- TOP_OFF: OCC_PART to OCC_FULL, taken on a push alone while one slot is free.
- RELEASE: OCC_FULL to OCC_PART, taken on an accepted pop.
- DRAIN_LAST: OCC_PART to OCC_EMPTY, taken on a pop alone while one byte is held.

Software reads the receive data word to dequeue a byte, and writes the transmit data word to enqueue one.

Top module: `uart_wm_regif`

## Requirements
- R1: After reset, both queues are empty and all control fields are zero. reg_rdata, both interrupts, tx_valid and rx_overrun are all low.
- R2: A write to byte address 0x00 pushes reg_wdata[7:0] into the transmit queue. tx_valid is high while the queue holds data, and tx_byte shows the oldest byte. tx_take removes that byte. Bytes leave in the order they were written.
- R3: A write to 0x00 is dropped when the transmit queue already holds 8 bytes, even if tx_take removes a byte in the same cycle.
- R4: A read of 0x00 returns bit 31 equal to 1 when the transmit queue is full, and zero in every other bit.
- R5: A read of 0x04 when the receive queue is not empty returns the oldest byte in bits 7:0 with bit 31 at 0. The same read removes that byte.
- R6: A read of 0x04 when the receive queue is empty returns 0x8000_0000 and leaves the queue unchanged.
- R7: 0x08 holds the transmit threshold in bits 18:16, two-stop select in bit 1 and transmit enable in bit 0. It reads back with zeros elsewhere. Bit 1 drives tx_two_stop and bit 0 drives tx_enable.
- R8: 0x0C holds the receive threshold in bits 18:16 and receive enable in bit 0. It reads back with zeros elsewhere. Bit 0 drives rx_enable.
- R9: irq_rx_wm is high exactly while irq_en_rx_wm is 1 and the receive count is strictly greater than the receive threshold.
- R10: irq_tx_wm is high exactly while irq_en_tx_wm is 1 and the transmit count is strictly less than the transmit threshold.
- R11: An rx_push while the receive queue holds 8 bytes discards the byte, even if a read dequeues in the same cycle. It also sets rx_overrun, which then stays set until reset.
- R12: Read data appears on reg_rdata in the cycle after the request and holds until the next read. Writes to 0x04 are ignored. Accesses with reg_addr[1:0] not zero are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access request this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_en_tx_wm | input | 1 | Transmit watermark interrupt enable |
| irq_en_rx_wm | input | 1 | Receive watermark interrupt enable |
| irq_tx_wm | output | 1 | Transmit watermark interrupt |
| irq_rx_wm | output | 1 | Receive watermark interrupt |
| tx_valid | output | 1 | Transmit queue holds a byte |
| tx_byte | output | 8 | Oldest transmit byte |
| tx_take | input | 1 | Transmitter removes the oldest byte |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Byte from the receiver |
| tx_enable | output | 1 | Transmit enable field |
| tx_two_stop | output | 1 | Two-stop-bit select field |
| rx_enable | output | 1 | Receive enable field |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench first fills the transmit queue one byte at a time with the threshold at 5. It then pushes past full and drains it. This separates a "strictly below" comparison from a "below or equal" one, and shows that a write to a full queue is lost.

The receive queue is driven to full and then past it. Next the threshold is lowered from 7 to 2 and the queue is drained by reads. This tells the strictly-above edge apart from off-by-one variants, and separates a dropped overrun byte from one that overwrites the queue.

Finally, a pseudo-random phase mixes writes, reads, takes and pushes in the same cycles. It exposes ordering faults between a simultaneous push and pop that the directed phases cannot reach.

// File: rtl/uart_wm_pkg.sv
`timescale 1ns/1ps
package uart_wm_pkg;
    // register select from byte address bits 3:2
    typedef enum logic [1:0] {
        SEL_TXDATA = 2'd0,
        SEL_RXDATA = 2'd1,
        SEL_TXCTRL = 2'd2,
        SEL_RXCTRL = 2'd3
    } reg_sel_e;

    // queue occupancy states
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

    localparam int BUS_W    = 32;
    localparam int FLAG_BIT = 31;
    localparam int THR_LSB  = 16;
    localparam int STOP_BIT = 1;
    localparam int EN_BIT   = 0;
endpackage

// File: rtl/uart_wm_fifo.sv
`timescale 1ns/1ps
module uart_wm_fifo
    import uart_wm_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    occ_state_e    state, state_nxt;
    logic          do_push, do_pop;

    assign do_push = push && (state != OCC_FULL);
    assign do_pop  = pop  && (state != OCC_EMPTY);

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            OCC_EMPTY: if (do_push) state_nxt = OCC_PART;                   // FILL
            OCC_PART: begin
                if (do_push && !do_pop && count == CW'(DEPTH - 1))
                    state_nxt = OCC_FULL;                                   // TOP_OFF
                else if (do_pop && !do_push && count == CW'(1))
                    state_nxt = OCC_EMPTY;                                  // DRAIN_LAST
            end
            OCC_FULL:  if (do_pop) state_nxt = OCC_PART;                    // RELEASE
            default:   state_nxt = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // outputs
    always_comb begin
        empty = (state == OCC_EMPTY);
        full  = (state == OCC_FULL);
        dout  = mem[rd_ptr];
    end

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_full_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count == CW'(DEPTH)));
    p_empty_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (count == '0));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/uart_wm_irq.sv
`timescale 1ns/1ps
module uart_wm_irq #(
    parameter int CW    = 4,
    parameter int TW    = 3,
    parameter bit ABOVE = 1'b1
) (
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] thr,
    input  logic          enable,
    output logic          irq
);
    logic hit;
    generate
        if (ABOVE) begin : g_above
            assign hit = count > CW'(thr);
        end else begin : g_below
            assign hit = count < CW'(thr);
        end
    endgenerate
    assign irq = enable && hit;
endmodule

// File: rtl/uart_wm_regs.sv
`timescale 1ns/1ps
module uart_wm_regs
    import uart_wm_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic             rx_full,
    input  logic [DW-1:0]    rx_head,
    input  logic             rx_push,
    output logic             tx_push,
    output logic [DW-1:0]    tx_push_data,
    output logic             rx_pop,
    output logic [TW-1:0]    tx_thr,
    output logic             tx_two_stop,
    output logic             tx_en,
    output logic [TW-1:0]    rx_thr,
    output logic             rx_en,
    output logic             rx_overrun
);
    reg_sel_e         sel_e;
    logic             aligned, rd_req, wr_req;
    logic [BUS_W-1:0] rd_word;

    assign sel_e   = reg_sel_e'(reg_addr[3:2]);
    assign aligned = (reg_addr[1:0] == 2'b00);
    assign rd_req  = reg_sel && !reg_wr && aligned;
    assign wr_req  = reg_sel &&  reg_wr && aligned;

    assign tx_push      = wr_req && (sel_e == SEL_TXDATA);
    assign tx_push_data = reg_wdata[DW-1:0];
    assign rx_pop       = rd_req && (sel_e == SEL_RXDATA);

    // read word selection
    always_comb begin
        rd_word = '0;
        unique case (sel_e)
            SEL_TXDATA: rd_word[FLAG_BIT] = tx_full;
            SEL_RXDATA: begin
                if (rx_empty) rd_word[FLAG_BIT] = 1'b1;
                else          rd_word[DW-1:0]   = rx_head;
            end
            SEL_TXCTRL: begin
                rd_word[THR_LSB +: TW] = tx_thr;
                rd_word[STOP_BIT]      = tx_two_stop;
                rd_word[EN_BIT]        = tx_en;
            end
            SEL_RXCTRL: begin
                rd_word[THR_LSB +: TW] = rx_thr;
                rd_word[EN_BIT]        = rx_en;
            end
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata   <= '0;
            tx_thr      <= '0;
            tx_two_stop <= 1'b0;
            tx_en       <= 1'b0;
            rx_thr      <= '0;
            rx_en       <= 1'b0;
            rx_overrun  <= 1'b0;
        end else begin
            if (rd_req) reg_rdata <= rd_word;
            if (wr_req && sel_e == SEL_TXCTRL) begin
                tx_thr      <= reg_wdata[THR_LSB +: TW];
                tx_two_stop <= reg_wdata[STOP_BIT];
                tx_en       <= reg_wdata[EN_BIT];
            end
            if (wr_req && sel_e == SEL_RXCTRL) begin
                rx_thr <= reg_wdata[THR_LSB +: TW];
                rx_en  <= reg_wdata[EN_BIT];
            end
            if (rx_push && rx_full) rx_overrun <= 1'b1;
        end
    end

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(reg_rdata));
    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty) |=> (reg_rdata == 32'h8000_0000));
    p_tx_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel_e == SEL_TXCTRL) |=> (tx_en == $past(reg_wdata[EN_BIT])));
    p_rx_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sel_e == SEL_RXCTRL) |=> (rx_en == $past(reg_wdata[EN_BIT])));
    p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);
    p_overrun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_overrun);
endmodule

// File: rtl/uart_wm_regif.sv
`timescale 1ns/1ps
module uart_wm_regif
    import uart_wm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int THR_W  = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              irq_en_tx_wm,
    input  logic              irq_en_rx_wm,
    output logic              irq_tx_wm,
    output logic              irq_rx_wm,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_take,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_enable,
    output logic              tx_two_stop,
    output logic              rx_enable,
    output logic              rx_overrun
);
    logic              tx_push, tx_full, tx_empty;
    logic [DATA_W-1:0] tx_push_data, rx_head;
    logic              rx_pop, rx_full, rx_empty;
    logic [CW-1:0]     tx_count, rx_count;
    logic [THR_W-1:0]  tx_thr, rx_thr;

    uart_wm_regs #(.DW(DATA_W), .TW(THR_W)) u_regs (
        .clk, .rst_n, .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .tx_full, .rx_empty, .rx_full, .rx_head, .rx_push,
        .tx_push, .tx_push_data, .rx_pop,
        .tx_thr, .tx_two_stop, .tx_en(tx_enable),
        .rx_thr, .rx_en(rx_enable), .rx_overrun
    );

    uart_wm_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk, .rst_n, .push(tx_push), .din(tx_push_data), .pop(tx_take),
        .dout(tx_byte), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    uart_wm_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk, .rst_n, .push(rx_push), .din(rx_byte), .pop(rx_pop),
        .dout(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    uart_wm_irq #(.CW(CW), .TW(THR_W), .ABOVE(1'b0)) u_tx_irq (
        .count(tx_count), .thr(tx_thr), .enable(irq_en_tx_wm), .irq(irq_tx_wm)
    );

    uart_wm_irq #(.CW(CW), .TW(THR_W), .ABOVE(1'b1)) u_rx_irq (
        .count(rx_count), .thr(rx_thr), .enable(irq_en_rx_wm), .irq(irq_rx_wm)
    );

    assign tx_valid = !tx_empty;

    p_tx_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_take) |=> (tx_valid && $stable(tx_byte)));
    p_rx_grow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_full && !rx_pop) |=> (rx_count == $past(rx_count) + 1'b1));
endmodule

// File: tb/uart_wm_regif_bench.sv
`timescale 1ns/1ps
module uart_wm_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 0, reg_wr = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        ie_tx = 0, ie_rx = 0;
    logic        irq_tx_wm, irq_rx_wm, tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_take = 0, rx_push = 0;
    logic [7:0]  rx_byte = 0;
    logic        tx_enable, tx_two_stop, rx_enable, rx_overrun;

    always #2 clk = ~clk;

    uart_wm_regif u_uart_wm_regif (
        .clk, .rst_n, .reg_sel, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .irq_en_tx_wm(ie_tx), .irq_en_rx_wm(ie_rx), .irq_tx_wm, .irq_rx_wm,
        .tx_valid, .tx_byte, .tx_take, .rx_push, .rx_byte,
        .tx_enable, .tx_two_stop, .rx_enable, .rx_overrun
    );

    int checks = 0, failures = 0;
    logic [7:0] txq[$], rxq[$];
    logic [2:0] m_tx_thr = 0, m_rx_thr = 0;
    logic m_two = 0, m_tx_en = 0, m_rx_en = 0, m_ovr = 0;
    logic [31:0] m_rd = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R12 rdata", reg_rdata, m_rd);
        chk("R2 tx_valid", 32'(tx_valid), 32'(txq.size() > 0));
        if (txq.size() > 0) chk("R2 tx_byte", 32'(tx_byte), 32'(txq[0]));
        chk("R10 irq_tx", 32'(irq_tx_wm), 32'(ie_tx && (txq.size() < int'(m_tx_thr))));
        chk("R9 irq_rx", 32'(irq_rx_wm), 32'(ie_rx && (rxq.size() > int'(m_rx_thr))));
        chk("R11 overrun", 32'(rx_overrun), 32'(m_ovr));
        chk("R7 tx_enable", 32'(tx_enable), 32'(m_tx_en));
        chk("R7 two_stop", 32'(tx_two_stop), 32'(m_two));
        chk("R8 rx_enable", 32'(rx_enable), 32'(m_rx_en));
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic sel, input logic wr, input logic [3:0] addr,
                        input logic [31:0] wd, input logic take,
                        input logic rp, input logic [7:0] rb);
        int pre_tx, pre_rx;
        reg_sel = sel; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        tx_take = take; rx_push = rp; rx_byte = rb;
        @(posedge clk);
        pre_tx = txq.size(); pre_rx = rxq.size();
        if (sel && !wr && addr[1:0] == 2'b00) begin
            case (addr[3:2])
                2'd0: m_rd = {(pre_tx == 8), 31'b0};
                2'd1: m_rd = (pre_rx == 0) ? 32'h8000_0000 : {24'b0, rxq[0]};
                2'd2: m_rd = {13'b0, m_tx_thr, 14'b0, m_two, m_tx_en};
                default: m_rd = {13'b0, m_rx_thr, 15'b0, m_rx_en};
            endcase
            if (addr[3:2] == 2'd1 && pre_rx > 0) void'(rxq.pop_front());
        end
        if (take && pre_tx > 0) void'(txq.pop_front());
        if (sel && wr && addr[1:0] == 2'b00) begin
            case (addr[3:2])
                2'd0: if (pre_tx < 8) txq.push_back(wd[7:0]);
                2'd2: begin m_tx_thr = wd[18:16]; m_two = wd[1]; m_tx_en = wd[0]; end
                2'd3: begin m_rx_thr = wd[18:16]; m_rx_en = wd[0]; end
                default: ;
            endcase
        end
        if (rp) begin
            if (pre_rx < 8) rxq.push_back(rb);
            else m_ovr = 1'b1;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();                               step(0, 0, 4'h0, 0, 0, 0, 0); endtask
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d); step(1, 1, a, d, 0, 0, 0); endtask
    task automatic rd_reg(input logic [3:0] a);          step(1, 0, a, 0, 0, 0, 0); endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        compare_all();                                    // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", reg_rdata, 32'h0);
        compare_all();

        // R7 / R8 control fields
        wr_reg(4'h8, 32'hFFF5_FFFF);
        rd_reg(4'h8);
        chk("R7 readback", reg_rdata, 32'h0005_0003);
        wr_reg(4'hC, 32'hFFFF_FFFE);
        rd_reg(4'hC);
        chk("R8 readback", reg_rdata, 32'h0007_0000);
        wr_reg(4'hC, 32'h0007_0001);

        // R10 / R2 / R3 / R4 transmit fill
        ie_tx = 1'b1;
        idle();
        chk("R10 irq_tx empty thr5", 32'(irq_tx_wm), 32'd1);
        for (int i = 0; i < 8; i++) wr_reg(4'h0, 32'hFFFF_FFA0 + i);
        chk("R10 irq_tx full", 32'(irq_tx_wm), 32'd0);
        rd_reg(4'h0);
        chk("R4 full flag", reg_rdata, 32'h8000_0000);
        wr_reg(4'h0, 32'h0000_00EE);                      // R3 dropped
        step(1, 1, 4'h0, 32'h0000_00EF, 1, 0, 0);         // R3 dropped with take
        chk("R3 head after drops", 32'(tx_byte), 32'hA1);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 0, 0);
        chk("R2 drained", 32'(tx_valid), 32'd0);
        rd_reg(4'h0);
        chk("R4 not full", reg_rdata, 32'h0);
        step(1, 1, 4'h0, 32'h0000_0055, 1, 0, 0);         // take on empty, push
        chk("R2 push with take on empty", 32'(tx_byte), 32'h55);
        step(0, 0, 0, 0, 1, 0, 0);

        // R9 / R11 / R5 / R6 receive
        ie_rx = 1'b1;
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, 8'h30 + 8'(i));
        chk("R9 irq_rx at 8 thr7", 32'(irq_rx_wm), 32'd1);
        step(1, 0, 4'h4, 0, 0, 1, 8'h99);                 // R11 drop with read
        chk("R11 overrun set", 32'(rx_overrun), 32'd1);
        chk("R5 head read", reg_rdata, 32'h0000_0030);
        wr_reg(4'hC, 32'h0002_0001);
        wr_reg(4'h4, 32'h0000_0077);                      // R12 ignored
        for (int i = 0; i < 7; i++) rd_reg(4'h4);
        chk("R11 last byte not overrun data", reg_rdata, 32'h0000_0037);
        chk("R9 irq_rx empty", 32'(irq_rx_wm), 32'd0);
        rd_reg(4'h4);
        chk("R6 empty read", reg_rdata, 32'h8000_0000);
        idle();
        chk("R12 rdata holds", reg_rdata, 32'h8000_0000);
        step(1, 0, 4'h9, 0, 0, 0, 0);                     // R12 misaligned
        chk("R12 misaligned ignored", reg_rdata, 32'h8000_0000);
        chk("R11 overrun sticky", 32'(rx_overrun), 32'd1);

        // mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[1], {lf[3:2], 2'b00}, {13'b0, lf[6:4], 14'b0, lf[7], 1'b1} | {24'b0, lf[15:8]},
                 lf[8], lf[9] & lf[10], lf[15:8]);
            if (i == 200) ie_rx = 1'b0;
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule